// File: doc/BRIEF.md
# Power Stage Fault and Mute Supervisor

This block decides, once per clock, whether a two-channel switching power stage may drive its outputs. It collects digital flags from external comparators (supply over-voltage, supply under-voltage, a current-limit warning, a current-shutdown trip and per-channel speaker presence). It also takes the external mute and sleep pins, a mute bit from a control register, and a signed level sample for each channel. From these it produces a stage enable, a request to reduce input gain, a muted status pin and a set of status and fault bits for a register file.

Some causes clear as soon as their condition goes away: supply faults, sleep and silence. The current-shutdown trip is held until the mute pin rises again. The speaker check applies only from reset until both speakers have been seen. After an external mute is released, the outputs wait a fixed number of millisecond ticks before they switch again. A silence timer mutes the stage when the combined input level stays low for a selectable time. `msTick` is a one-cycle strobe that arrives once per millisecond.

Top module: `amp_guard`

## Requirements
- R1: While `ovFlag` or `uvFlag` is high, the stage is disabled, `hmute` is 1, `fltVoltage` is 1 and `muteCause` is 3. One cycle after both flags are low, operation resumes with nothing latched.
- R2: `ocLimFlag` never disables the stage. It drives `gainReduce` high one cycle later and sets the sticky bit `stOcSticky`. A pulse on `ocStickyClr` clears that bit. When a clear and a new flag arrive in the same cycle, the set wins.
- R3: `ocShutFlag` disables the stage and sets `fltOcShut` (`muteCause` 2). The fault stays latched after the flag drops. Only a rising edge of `mutePin` or a reset clears it. A falling edge of `mutePin` does not clear it.
- R4: `mutePin` or `regMute` high disables the stage with `muteCause` 5.
- R5: After both `mutePin` and `regMute` are low, the stage stays muted (`muteCause` 5) for UNMUTE_MS `msTick` pulses. It re-enables one cycle after the last of those pulses.
- R6: When the sum of the two channel magnitudes stays strictly below the selected threshold for the selected time, the stage mutes with `muteCause` 6 and `stSilence` 1. It un-mutes within two cycles after the sum reaches the threshold.
- R7: `silTimeSel` selects the silence time in `msTick` pulses: 00 = 4×SIL_BASE_MS, 01 = SIL_BASE_MS, 10 = 8×SIL_BASE_MS, 11 = silence muting disabled. SIL_BASE_MS defaults to 85000.
- R8: `silLevelSel` selects the threshold on the magnitude sum for 16-bit samples: 00 = 3, 01 = 7, 10 = 13, 11 = 26. A sum equal to the threshold counts as not quiet.
- R9: From reset, the stage stays muted (`muteCause` 4) until both bits of `spkPresent` have been 1 in the same cycle. Once that has happened, a speaker that disappears later has no effect.
- R10: `sleepPin` high disables the stage, sets `lowPower` and gives `muteCause` 1.
- R11: When several causes are active, `muteCause` reports the one with the highest priority. The order is sleep (1), latched current trip (2), supply fault (3), missing speaker (4), external mute or un-mute wait (5), silence (6). Code 0 means no cause. `hmute` and `stMuted` are 1 exactly when the code is not 0, and `stageEn` is their inverse.
- R12: In reset, `stageEn` is 0, `hmute` is 1, `muteCause` is 4, and all status and fault bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous reset, active low |
| msTick | input | 1 | one-cycle pulse per millisecond |
| ovFlag | input | 1 | supply over-voltage comparator |
| uvFlag | input | 1 | supply under-voltage comparator |
| ocLimFlag | input | 1 | current-limit warning comparator |
| ocShutFlag | input | 1 | current-shutdown trip comparator |
| spkPresent | input | 2 | speaker detected, one bit per channel |
| mutePin | input | 1 | external mute request |
| sleepPin | input | 1 | external sleep request |
| regMute | input | 1 | mute bit from the control register |
| ocStickyClr | input | 1 | software clear of the sticky limit bit |
| silTimeSel | input | 2 | silence time code |
| silLevelSel | input | 2 | silence threshold code |
| lvlCh0 | input | LEVEL_W | signed level sample, channel 0 |
| lvlCh1 | input | LEVEL_W | signed level sample, channel 1 |
| stageEn | output | 1 | power stage may switch |
| hmute | output | 1 | muted status pin |
| gainReduce | output | 1 | request to reduce input gain |
| lowPower | output | 1 | sleep indication |
| muteCause | output | 3 | code of the highest-priority mute cause |
| stMuted | output | 1 | status: outputs muted |
| stSilence | output | 1 | status: silence mute active |
| stOcSticky | output | 1 | status: sticky current-limit event |
| fltOcShut | output | 1 | fault: latched current trip |
| fltVoltage | output | 1 | fault: supply out of range |

## Verification
The hardest case to reach is a latched current trip that occurs while `mutePin` is already high. The pin must be driven low (which must not clear the fault) and then high again. The stimulus builds this case on purpose. It raises mute, fires a one-cycle trip, releases mute, and then re-asserts it, checking the cause code at each step. The silence timer is reached by shrinking the base time through a parameter. Sums one below and exactly at the threshold are then applied, with opposite-sign samples so that the magnitude logic is exercised.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_SLEEP   = 3'd1,
    CAUSE_OCLATCH = 3'd2,
    CAUSE_VOLT    = 3'd3,
    CAUSE_SPK     = 3'd4,
    CAUSE_EXTMUTE = 3'd5,
    CAUSE_SILENCE = 3'd6
  } muteCause_e;

  // control -> datapath strobes
  typedef struct packed {
    logic holdStart;   // an external mute request is active
    logic silReset;    // clear the silence timer
  } dpCmd_t;

  // datapath -> control state
  typedef struct packed {
    logic holdBusy;    // un-mute wait still running
    logic silent;      // quiet long enough
  } dpStat_t;

  // quiet threshold on the summed magnitude for 16-bit samples
  function automatic logic [5:0] silThreshold(input logic [1:0] code);
    case (code)
      2'b00:   return 6'd3;
      2'b01:   return 6'd7;
      2'b10:   return 6'd13;
      default: return 6'd26;
    endcase
  endfunction

endpackage

// File: rtl/amp_guard_dp.sv
module amp_guard_dp
  import amp_guard_pkg::*;
#(
  parameter int LEVEL_W     = 16,
  parameter int SIL_BASE_MS = 85000,
  parameter int UNMUTE_MS   = 200
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               msTick,
  input  dpCmd_t             cmd,
  input  logic [1:0]         silTimeSel,
  input  logic [1:0]         silLevelSel,
  input  logic [LEVEL_W-1:0] lvl [2],
  output dpStat_t            stat
);

  localparam int SUM_W   = LEVEL_W + 1;
  localparam int SIL_CW  = $clog2(8 * SIL_BASE_MS + 1);
  localparam int HOLD_CW = $clog2(UNMUTE_MS + 1);

  logic [LEVEL_W-1:0] mag [2];
  logic [SUM_W-1:0]   levelSum;
  logic [SIL_CW-1:0]  silLimit;
  logic [SIL_CW-1:0]  silCnt;
  logic [HOLD_CW-1:0] holdCnt;
  logic               silEnable;
  logic               quiet;
  logic               holdBusy;
  logic               silent;

  // magnitude of each signed sample
  for (genvar g = 0; g < 2; g++) begin : gMag
    assign mag[g] = lvl[g][LEVEL_W-1] ? (~lvl[g] + LEVEL_W'(1)) : lvl[g];
  end

  assign levelSum = {1'b0, mag[0]} + {1'b0, mag[1]};
  assign quiet    = levelSum < SUM_W'(silThreshold(silLevelSel));

  always_comb begin
    silEnable = 1'b1;
    case (silTimeSel)
      2'b00:   silLimit = SIL_CW'(4 * SIL_BASE_MS);
      2'b01:   silLimit = SIL_CW'(SIL_BASE_MS);
      2'b10:   silLimit = SIL_CW'(8 * SIL_BASE_MS);
      default: begin
        silLimit  = '0;
        silEnable = 1'b0;
      end
    endcase
  end

  // un-mute wait counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdBusy <= 1'b0;
      holdCnt  <= '0;
    end else if (cmd.holdStart) begin
      holdBusy <= 1'b1;
      holdCnt  <= '0;
    end else if (holdBusy && msTick) begin
      if (holdCnt == HOLD_CW'(UNMUTE_MS - 1)) holdBusy <= 1'b0;
      else                                    holdCnt  <= holdCnt + 1'b1;
    end
  end

  // silence timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      silCnt <= '0;
      silent <= 1'b0;
    end else if (cmd.silReset || !silEnable || !quiet) begin
      silCnt <= '0;
      silent <= 1'b0;
    end else if (msTick && !silent) begin
      if (silCnt == silLimit - 1'b1) silent <= 1'b1;
      else                           silCnt <= silCnt + 1'b1;
    end
  end

  assign stat.holdBusy = holdBusy;
  assign stat.silent   = silent;

endmodule

// File: rtl/amp_guard_ctl.sv
module amp_guard_ctl
  import amp_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ovFlag,
  input  logic       uvFlag,
  input  logic       ocLimFlag,
  input  logic       ocShutFlag,
  input  logic [1:0] spkPresent,
  input  logic       mutePin,
  input  logic       sleepPin,
  input  logic       regMute,
  input  logic       ocStickyClr,
  input  dpStat_t    stat,
  output dpCmd_t     cmd,
  output muteCause_e causeR,
  output logic       lowPowerR,
  output logic       gainR,
  output logic       ocStickyR,
  output logic       ocLatchR,
  output logic       voltR,
  output logic       silStR
);

  logic       mutePrevR;
  logic       spkHoldR;
  logic       muteRise;
  logic       ocLatchNx;
  logic       spkHoldNx;
  logic       extMute;
  muteCause_e causeNx;

  assign cmd.holdStart = mutePin | regMute;
  assign cmd.silReset  = sleepPin;

  always_comb begin
    muteRise  = mutePin & ~mutePrevR;
    ocLatchNx = ocShutFlag | (ocLatchR & ~muteRise);
    spkHoldNx = spkHoldR & ~(&spkPresent);
    extMute   = mutePin | regMute | stat.holdBusy;
    if (sleepPin)              causeNx = CAUSE_SLEEP;
    else if (ocLatchNx)        causeNx = CAUSE_OCLATCH;
    else if (ovFlag || uvFlag) causeNx = CAUSE_VOLT;
    else if (spkHoldNx)        causeNx = CAUSE_SPK;
    else if (extMute)          causeNx = CAUSE_EXTMUTE;
    else if (stat.silent)      causeNx = CAUSE_SILENCE;
    else                       causeNx = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeR    <= CAUSE_SPK;
      mutePrevR <= 1'b0;
      spkHoldR  <= 1'b1;
      ocLatchR  <= 1'b0;
      lowPowerR <= 1'b0;
      gainR     <= 1'b0;
      ocStickyR <= 1'b0;
      voltR     <= 1'b0;
      silStR    <= 1'b0;
    end else begin
      causeR    <= causeNx;
      mutePrevR <= mutePin;
      spkHoldR  <= spkHoldNx;
      ocLatchR  <= ocLatchNx;
      lowPowerR <= sleepPin;
      gainR     <= ocLimFlag;
      ocStickyR <= ocLimFlag | (ocStickyR & ~ocStickyClr);
      voltR     <= ovFlag | uvFlag;
      silStR    <= stat.silent;
    end
  end

endmodule

// File: rtl/amp_guard.sv
module amp_guard
  import amp_guard_pkg::*;
#(
  parameter int LEVEL_W     = 16,
  parameter int SIL_BASE_MS = 85000,
  parameter int UNMUTE_MS   = 200
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               msTick,
  input  logic               ovFlag,
  input  logic               uvFlag,
  input  logic               ocLimFlag,
  input  logic               ocShutFlag,
  input  logic [1:0]         spkPresent,
  input  logic               mutePin,
  input  logic               sleepPin,
  input  logic               regMute,
  input  logic               ocStickyClr,
  input  logic [1:0]         silTimeSel,
  input  logic [1:0]         silLevelSel,
  input  logic [LEVEL_W-1:0] lvlCh0,
  input  logic [LEVEL_W-1:0] lvlCh1,
  output logic               stageEn,
  output logic               hmute,
  output logic               gainReduce,
  output logic               lowPower,
  output logic [2:0]         muteCause,
  output logic               stMuted,
  output logic               stSilence,
  output logic               stOcSticky,
  output logic               fltOcShut,
  output logic               fltVoltage
);

  dpCmd_t             cmd;
  dpStat_t            stat;
  muteCause_e         causeR;
  logic [LEVEL_W-1:0] lvlArr [2];

  assign lvlArr[0] = lvlCh0;
  assign lvlArr[1] = lvlCh1;

  amp_guard_dp #(
    .LEVEL_W(LEVEL_W), .SIL_BASE_MS(SIL_BASE_MS), .UNMUTE_MS(UNMUTE_MS)
  ) uDp (
    .clk(clk), .rstN(rstN), .msTick(msTick), .cmd(cmd),
    .silTimeSel(silTimeSel), .silLevelSel(silLevelSel),
    .lvl(lvlArr), .stat(stat)
  );

  amp_guard_ctl uCtl (
    .clk(clk), .rstN(rstN), .ovFlag(ovFlag), .uvFlag(uvFlag),
    .ocLimFlag(ocLimFlag), .ocShutFlag(ocShutFlag), .spkPresent(spkPresent),
    .mutePin(mutePin), .sleepPin(sleepPin), .regMute(regMute),
    .ocStickyClr(ocStickyClr), .stat(stat), .cmd(cmd), .causeR(causeR),
    .lowPowerR(lowPower), .gainR(gainReduce), .ocStickyR(stOcSticky),
    .ocLatchR(fltOcShut), .voltR(fltVoltage), .silStR(stSilence)
  );

  assign muteCause = causeR;
  assign stageEn   = (causeR == CAUSE_NONE);
  assign hmute     = ~stageEn;
  assign stMuted   = ~stageEn;

endmodule

// File: rtl/amp_guard_chk.sv
module amp_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ovFlag,
  input logic       uvFlag,
  input logic       ocLimFlag,
  input logic       ocShutFlag,
  input logic       mutePin,
  input logic       regMute,
  input logic       sleepPin,
  input logic       stageEn,
  input logic       hmute,
  input logic       gainReduce,
  input logic       stOcSticky,
  input logic       fltOcShut,
  input logic       lowPower,
  input logic [2:0] muteCause
);

  assert_volt_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ovFlag || uvFlag) |=> (!stageEn && hmute));

  assert_limit_gain_R2: assert property (@(posedge clk) disable iff (!rstN)
    ocLimFlag |=> (gainReduce && stOcSticky));

  assert_trip_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    ocShutFlag |=> (fltOcShut && !stageEn));

  assert_trip_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fltOcShut && !$rose(mutePin)) |=> fltOcShut);

  assert_ext_mute_R4: assert property (@(posedge clk) disable iff (!rstN)
    (mutePin || regMute) |=> !stageEn);

  assert_sleep_R10: assert property (@(posedge clk) disable iff (!rstN)
    sleepPin |=> (lowPower && !stageEn && muteCause == 3'd1));

endmodule

bind amp_guard amp_guard_chk u_chk (.*);

// File: tb/sim_amp_guard.sv
module sim_amp_guard;

  localparam int LW = 16;
  localparam int B  = 4;
  localparam int U  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b1;
  logic ovFlag = 0, uvFlag = 0, ocLimFlag = 0, ocShutFlag = 0;
  logic [1:0] spkPresent = 2'b01;
  logic mutePin = 0, sleepPin = 0, regMute = 0, ocStickyClr = 0;
  logic [1:0] silTimeSel = 2'b11, silLevelSel = 2'b00;
  logic [LW-1:0] lvlCh0 = 16'd1000, lvlCh1 = 16'd1000;
  logic stageEn, hmute, gainReduce, lowPower, stMuted, stSilence, stOcSticky, fltOcShut, fltVoltage;
  logic [2:0] muteCause;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    string tag;
    int    kind;   // 0 = cause code, 1 = flag
    int    which;
    int    val;
  } expItem_t;

  expItem_t expQ[$];

  always #2 clk = ~clk;

  amp_guard #(.LEVEL_W(LW), .SIL_BASE_MS(B), .UNMUTE_MS(U)) u0 (
    .clk(clk), .rstN(rstN), .msTick(msTick), .ovFlag(ovFlag), .uvFlag(uvFlag),
    .ocLimFlag(ocLimFlag), .ocShutFlag(ocShutFlag), .spkPresent(spkPresent),
    .mutePin(mutePin), .sleepPin(sleepPin), .regMute(regMute),
    .ocStickyClr(ocStickyClr), .silTimeSel(silTimeSel), .silLevelSel(silLevelSel),
    .lvlCh0(lvlCh0), .lvlCh1(lvlCh1), .stageEn(stageEn), .hmute(hmute),
    .gainReduce(gainReduce), .lowPower(lowPower), .muteCause(muteCause),
    .stMuted(stMuted), .stSilence(stSilence), .stOcSticky(stOcSticky),
    .fltOcShut(fltOcShut), .fltVoltage(fltVoltage)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expCause(input string tag, input int c);
    expItem_t it;
    it.tag = tag; it.kind = 0; it.which = 0; it.val = c;
    expQ.push_back(it);
  endtask

  // flag index: 0 lowPower 1 gainReduce 2 stOcSticky 3 fltOcShut 4 fltVoltage 5 stSilence
  task automatic expFlag(input string tag, input int which, input int v);
    expItem_t it;
    it.tag = tag; it.kind = 1; it.which = which; it.val = v;
    expQ.push_back(it);
  endtask

  function automatic int flagVal(input int which);
    case (which)
      0: return int'(lowPower);
      1: return int'(gainReduce);
      2: return int'(stOcSticky);
      3: return int'(fltOcShut);
      4: return int'(fltVoltage);
      default: return int'(stSilence);
    endcase
  endfunction

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      expItem_t it;
      int act;
      wait (expQ.size() != 0);
      it = expQ.pop_front();
      checks++;
      if (it.kind == 0) begin
        act = int'(muteCause);
        if (act != it.val || stageEn != (it.val == 0) || hmute != (it.val != 0)
            || stMuted != (it.val != 0)) begin
          fails++;
          $display("FAIL %s: cause=%0d stageEn=%0b hmute=%0b expected cause=%0d",
                   it.tag, act, stageEn, hmute, it.val);
        end
      end else begin
        act = flagVal(it.which);
        if (act != it.val) begin
          fails++;
          $display("FAIL %s: flag%0d=%0d expected %0d", it.tag, it.which, act, it.val);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    // R12 reset state
    expCause("R12 reset", 4);
    for (int i = 0; i < 6; i++) expFlag("R12 reset flags", i, 0);
    rstN = 1'b1;

    // R9 speaker missing at start
    step(3);
    expCause("R9 one speaker", 4);
    spkPresent = 2'b11; step(1);
    expCause("R9 both present", 0);
    spkPresent = 2'b10; step(3);
    expCause("R9 later loss ignored", 0);

    // R1 supply faults
    ovFlag = 1; step(1);
    expCause("R1 over-voltage", 3); expFlag("R1 fault bit", 4, 1);
    ovFlag = 0; step(1);
    expCause("R1 recovers", 0); expFlag("R1 fault clears", 4, 0);
    uvFlag = 1; step(1);
    expCause("R1 under-voltage", 3);
    uvFlag = 0; step(1);
    expCause("R1 under-voltage recovers", 0);

    // R2 current limit
    ocLimFlag = 1; step(1);
    expCause("R2 limit keeps stage on", 0);
    expFlag("R2 gain reduce", 1, 1); expFlag("R2 sticky set", 2, 1);
    ocLimFlag = 0; step(2);
    expFlag("R2 gain drops", 1, 0); expFlag("R2 sticky holds", 2, 1);
    ocStickyClr = 1; step(1); ocStickyClr = 0;
    expFlag("R2 sticky cleared", 2, 0);
    ocLimFlag = 1; ocStickyClr = 1; step(1); ocLimFlag = 0; ocStickyClr = 0;
    expFlag("R2 set wins over clear", 2, 1);
    ocStickyClr = 1; step(1); ocStickyClr = 0;

    // R3 latched trip, cleared by mute rise
    ocShutFlag = 1; step(1); ocShutFlag = 0;
    expCause("R3 trip", 2); expFlag("R3 fault bit", 3, 1);
    step(5);
    expCause("R3 stays latched", 2);
    mutePin = 1; step(1);
    expCause("R3 cleared by mute rise, R4 mute", 5); expFlag("R3 fault cleared", 3, 0);
    step(2); mutePin = 0;
    // R5 un-mute wait
    step(U);
    expCause("R5 still waiting", 5);
    step(1);
    expCause("R5 released", 0);

    // R3 trip while mute already high: falling edge must not clear
    mutePin = 1; step(2);
    ocShutFlag = 1; step(1); ocShutFlag = 0;
    step(2);
    expCause("R3 trip during mute", 2);
    mutePin = 0; step(1);
    expCause("R3 mute fall does not clear", 2);
    mutePin = 1; step(1);
    expCause("R3 second rise clears", 5);
    mutePin = 0; step(U + 1);
    expCause("R5 released again", 0);

    // R11 priority with R10 sleep
    ovFlag = 1; mutePin = 1; sleepPin = 1; step(1);
    expCause("R10 sleep wins R11", 1); expFlag("R10 low power", 0, 1);
    sleepPin = 0; step(1);
    expCause("R11 voltage over mute", 3); expFlag("R10 low power off", 0, 0);
    ovFlag = 0; step(1);
    expCause("R11 mute next", 5);
    mutePin = 0; step(U + 1);
    expCause("R11 all clear", 0);

    // R4 register mute bit
    regMute = 1; step(1);
    expCause("R4 register mute", 5);
    regMute = 0; step(U);
    expCause("R5 wait after register mute", 5);
    step(1);
    expCause("R4 register mute released", 0);

    // R6 R7 R8 silence, code 01 = B ticks, threshold 3, sum 2
    silTimeSel = 2'b01; silLevelSel = 2'b00;
    lvlCh0 = 16'd1; lvlCh1 = 16'hFFFF;
    step(B);
    expCause("R7 base time not yet", 0);
    step(1);
    expCause("R6 silence mute", 6); expFlag("R6 silence bit", 5, 1);
    lvlCh0 = 16'd500; step(2);
    expCause("R6 quick un-mute", 0); expFlag("R6 silence bit off", 5, 0);
    lvlCh0 = 16'd2; step(20);
    expCause("R8 sum equal threshold not quiet", 0);
    silLevelSel = 2'b11; lvlCh0 = 16'd20; lvlCh1 = 16'hFFFB; step(B + 1);
    expCause("R8 code 11 threshold 26", 6);
    lvlCh0 = 16'd26; lvlCh1 = 16'd0; step(2);
    expCause("R8 sum 26 not quiet", 0);

    // R7 code 00 = 4B, code 10 = 8B, code 11 off
    silTimeSel = 2'b00; lvlCh0 = 16'd0; step(4 * B);
    expCause("R7 code 00 not yet", 0);
    step(1);
    expCause("R7 code 00 expires", 6);
    lvlCh0 = 16'd1000; step(2);
    silTimeSel = 2'b10; lvlCh0 = 16'd0; step(8 * B);
    expCause("R7 code 10 not yet", 0);
    step(1);
    expCause("R7 code 10 expires", 6);
    lvlCh0 = 16'd1000; step(2);
    silTimeSel = 2'b11; lvlCh0 = 16'd0; step(100);
    expCause("R7 code 11 disabled", 0);

    wait (expQ.size() == 0);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule